// File: doc/BRIEF.md
# Transfer Submit and ID Tracker

This block keeps the books for one DMA channel's transfer queue. Software sets a submit bit to ask for a transfer to be queued. While the channel is enabled and a slot is free, the block offers the request to the transfer engine. It tags the request with a 2-bit ID, and it moves the submit bit back to zero once the engine takes the request. Up to four transfers can be outstanding at once. A fifth request waits, with its submit bit held at one, until a completion frees a slot.

Each of the four IDs has a done flag. The flag is cleared when its ID is handed out again and is set when the engine reports that transfer finished. The block also tracks which ID the engine is working on. Completions arrive in order, so an active pointer advances by one on each completion. When nothing is outstanding, the active-ID output shows the ID that will be handed out next. Clearing the channel enable drops any pending request, forgets the outstanding count and returns both the next ID and the active pointer to zero. The done flags are kept.

Top module: `xid_tracker`

## Requirements
- R1: After reset the submit bit, q_valid and queued_evt are 0, next_id and active_id are 0, and all done_bits are 0.
- R2: A write strobe carrying data 1 while enable is high sets the submit bit from the next cycle on. A write carrying data 0 leaves the submit bit unchanged.
- R3: q_valid is high exactly when the submit bit is 1, enable is high and fewer than four transfers are outstanding. q_id always equals next_id.
- R4: The submit bit reads 0 in the cycle after an acceptance (q_valid and q_ready both high), unless a write of 1 arrives in that same cycle. It reads 0 in the cycle after any cycle with enable low, and writes made while enable is low are ignored.
- R5: next_id advances by one modulo 4 on each acceptance and returns to 0 in the cycle after enable is low.
- R6: On an acceptance, bit q_id of done_bits reads 0 from the next cycle.
- R7: A completion (cmpl_valid high) taken while enable is high and at least one transfer is outstanding sets bit cmpl_id of done_bits from the next cycle. A completion with nothing outstanding, or with enable low, changes no output.
- R8: active_id equals next_id while nothing is outstanding. Otherwise it shows a pointer that starts at 0, advances by one modulo 4 on each counted completion and returns to 0 when enable is low.
- R9: queued_evt is high for one cycle, in the cycle right after each acceptance, and low otherwise.
- R10: With four transfers outstanding q_valid stays low, and a pending submit bit stays 1 until a completion frees a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable level from the control register |
| submit_wr | input | 1 | Write strobe for the submit bit |
| submit_wdata | input | 1 | Data written with submit_wr |
| submit_bit | output | 1 | Readback of the submit bit |
| q_valid | output | 1 | Queue request towards the transfer engine |
| q_ready | input | 1 | Engine accepts the request this cycle |
| q_id | output | 2 | ID attached to the offered request |
| cmpl_valid | input | 1 | Completion pulse from the engine |
| cmpl_id | input | 2 | ID of the completed transfer |
| next_id | output | 2 | ID the next accepted transfer will get |
| active_id | output | 2 | ID of the transfer the engine is working on |
| done_bits | output | 4 | One done flag per ID, bit x for ID x |
| queued_evt | output | 1 | One-cycle pulse after each acceptance |

## Verification
A wrong outstanding count shows up first at q_valid. If it is too high, a request is held back while the queue still has room. If it is too low, a fifth transfer is offered and gets an ID that is still in use. A slipped next-ID or active pointer shows up at next_id, q_id or active_id in the cycle after the faulty update. A done flag that is missed or cleared at the wrong time shows up in done_bits one cycle after the acceptance or completion that should have changed it. Software reading done_bits would then wrongly take a transfer for finished or still running.

// File: rtl/xid_pkg.sv
package xid_pkg;
  // default width of a transfer ID; the number of slots is 2**width
  localparam int unsigned XID_W_DEFAULT = 2;

  // how one counted event moves the outstanding count
  typedef enum logic [1:0] {
    CNT_HOLD = 2'b00,
    CNT_DEC  = 2'b01,
    CNT_INC  = 2'b10,
    CNT_BOTH = 2'b11
  } cnt_move_e;
endpackage

// File: rtl/xid_submit_ctrl.sv
module xid_submit_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic wr,
  input  logic wdata,
  input  logic slots_full,
  input  logic q_ready,
  output logic sub_bit,
  output logic q_valid,
  output logic accept
);
  logic sub_q;
  logic sub_d;
  logic set_req;

  assign set_req = wr & wdata;
  assign q_valid = sub_q & enable & ~slots_full;
  assign accept  = q_valid & q_ready;
  assign sub_bit = sub_q;

  always_comb begin
    sub_d = sub_q;
    if (!enable) begin
      sub_d = 1'b0;
    end else if (set_req) begin
      sub_d = 1'b1;
    end else if (accept) begin
      sub_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= 1'b0;
    end else begin
      sub_q <= sub_d;
    end
  end

  AST_SUBMIT_CLEARS_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !set_req |=> !sub_q); // R4
  AST_SUBMIT_CLEARS_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !sub_q); // R4
  AST_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    enable && set_req |=> sub_q); // R2
endmodule

// File: rtl/xid_seq.sv
module xid_seq
  import xid_pkg::*;
#(
  parameter int unsigned ID_W = XID_W_DEFAULT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            accept,
  input  logic            cmpl_valid,
  output logic            cmpl_fire,
  output logic            slots_full,
  output logic [ID_W-1:0] next_id,
  output logic [ID_W-1:0] active_id,
  output logic            queued_evt
);
  localparam int unsigned NUM_IDS = 1 << ID_W;
  localparam int unsigned CNT_W   = ID_W + 1;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NUM_IDS);
  localparam logic [ID_W-1:0]  ID_ONE   = ID_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ID_W-1:0]  next_q, next_d;
  logic [ID_W-1:0]  act_q, act_d;
  logic             evt_q, evt_d;
  cnt_move_e        move;

  assign cmpl_fire  = cmpl_valid & enable & (cnt_q != '0);
  assign slots_full = (cnt_q == CNT_FULL);
  assign next_id    = next_q;
  assign active_id  = (cnt_q == '0) ? next_q : act_q;
  assign queued_evt = evt_q;
  assign move       = cnt_move_e'({accept, cmpl_fire});

  always_comb begin
    cnt_d  = cnt_q;
    next_d = next_q;
    act_d  = act_q;
    evt_d  = accept;
    if (!enable) begin
      cnt_d  = '0;
      next_d = '0;
      act_d  = '0;
    end else begin
      case (move)
        CNT_INC: cnt_d = cnt_q + CNT_ONE;
        CNT_DEC: cnt_d = cnt_q - CNT_ONE;
        default: cnt_d = cnt_q;
      endcase
      if (accept) begin
        next_d = next_q + ID_ONE;
      end
      if (cmpl_fire) begin
        act_d = act_q + ID_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      next_q <= '0;
      act_q  <= '0;
      evt_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      next_q <= next_d;
      act_q  <= act_d;
      evt_q  <= evt_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL); // R10
  AST_NEXT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> next_q == $past(next_q) + ID_ONE); // R5
  AST_NEXT_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> next_q == '0); // R5
  AST_ACTIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> active_id == '0); // R8
endmodule

// File: rtl/xid_done_map.sv
module xid_done_map
  import xid_pkg::*;
#(
  parameter int unsigned ID_W = XID_W_DEFAULT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_en,
  input  logic [ID_W-1:0]        clr_id,
  input  logic                   set_en,
  input  logic [ID_W-1:0]        set_id,
  output logic [(1<<ID_W)-1:0]   done
);
  localparam int unsigned NUM_IDS = 1 << ID_W;

  logic [NUM_IDS-1:0] done_q;

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_flag
    logic hit_clr, hit_set, flag_d;
    assign hit_clr = clr_en && (clr_id == ID_W'(g));
    assign hit_set = set_en && (set_id == ID_W'(g));
    always_comb begin
      flag_d = done_q[g];
      if (hit_clr) flag_d = 1'b0;
      if (hit_set) flag_d = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        done_q[g] <= 1'b0;
      end else if (hit_clr || hit_set) begin
        done_q[g] <= flag_d;
      end
    end
  end

  assign done = done_q;

  AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en && !(set_en && set_id == clr_id) |=> !done_q[$past(clr_id)]); // R6
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> done_q[$past(set_id)]); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en && !set_en |=> $stable(done_q)); // R7
endmodule

// File: rtl/xid_tracker.sv
module xid_tracker
  import xid_pkg::*;
#(
  parameter int unsigned ID_W = XID_W_DEFAULT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 submit_wr,
  input  logic                 submit_wdata,
  output logic                 submit_bit,
  output logic                 q_valid,
  input  logic                 q_ready,
  output logic [ID_W-1:0]      q_id,
  input  logic                 cmpl_valid,
  input  logic [ID_W-1:0]      cmpl_id,
  output logic [ID_W-1:0]      next_id,
  output logic [ID_W-1:0]      active_id,
  output logic [(1<<ID_W)-1:0] done_bits,
  output logic                 queued_evt
);
  localparam logic [ID_W-1:0] ID_ONE = ID_W'(1);

  logic accept;
  logic slots_full;
  logic cmpl_fire;

  xid_submit_ctrl u_sub (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .wr         (submit_wr),
    .wdata      (submit_wdata),
    .slots_full (slots_full),
    .q_ready    (q_ready),
    .sub_bit    (submit_bit),
    .q_valid    (q_valid),
    .accept     (accept)
  );

  xid_seq #(.ID_W(ID_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .accept     (accept),
    .cmpl_valid (cmpl_valid),
    .cmpl_fire  (cmpl_fire),
    .slots_full (slots_full),
    .next_id    (next_id),
    .active_id  (active_id),
    .queued_evt (queued_evt)
  );

  assign q_id = next_id;

  xid_done_map #(.ID_W(ID_W)) u_done (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_en (accept),
    .clr_id (q_id),
    .set_en (cmpl_fire),
    .set_id (cmpl_id),
    .done   (done_bits)
  );

  AST_NO_ACCEPT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    slots_full |-> !q_valid); // R10
  AST_EVT_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    queued_evt |-> next_id == $past(next_id) + ID_ONE); // R9
  AST_VALID_NEEDS_SUBMIT: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> submit_bit && enable); // R3
endmodule

// File: tb/xid_tracker_tb.sv
module xid_tracker_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       submit_wr = 1'b0;
  logic       submit_wdata = 1'b0;
  logic       q_ready = 1'b0;
  logic       cmpl_valid = 1'b0;
  logic [1:0] cmpl_id = 2'd0;
  logic       submit_bit, q_valid, queued_evt;
  logic [1:0] q_id, next_id, active_id;
  logic [3:0] done_bits;

  int unsigned total = 0;
  int unsigned bad = 0;
  bit finished = 1'b0;

  // bench-side model state
  bit       m_sub;
  bit [1:0] m_next, m_act;
  int       m_cnt;
  bit [3:0] m_done;
  bit       m_evt;

  always #10 clk = ~clk;

  xid_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .submit_wr(submit_wr), .submit_wdata(submit_wdata), .submit_bit(submit_bit),
    .q_valid(q_valid), .q_ready(q_ready), .q_id(q_id),
    .cmpl_valid(cmpl_valid), .cmpl_id(cmpl_id),
    .next_id(next_id), .active_id(active_id), .done_bits(done_bits),
    .queued_evt(queued_evt)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic bit exp_valid();
    return m_sub && enable && (m_cnt < 4);
  endfunction

  function automatic bit [1:0] exp_active();
    return (m_cnt == 0) ? m_next : m_act;
  endfunction

  task automatic check_outputs();
    chk("R2/R4 submit_bit", submit_bit, m_sub);
    chk("R3 q_valid", q_valid, exp_valid());
    chk("R3 q_id", q_id, m_next);
    chk("R5 next_id", next_id, m_next);
    chk("R8 active_id", active_id, exp_active());
    chk("R6/R7 done_bits", done_bits, m_done);
    chk("R9 queued_evt", queued_evt, m_evt);
    if (m_cnt == 4) chk("R10 full blocks", q_valid, 0);
  endtask

  task automatic model_step();
    bit acc, fire;
    acc  = exp_valid() && q_ready;
    fire = cmpl_valid && enable && (m_cnt != 0);
    if (acc)  m_done[m_next] = 1'b0;
    if (fire) m_done[cmpl_id] = 1'b1;
    m_evt = acc;
    if (!enable) begin
      m_sub = 0; m_next = 0; m_act = 0; m_cnt = 0;
    end else begin
      if (submit_wr && submit_wdata) m_sub = 1;
      else if (acc) m_sub = 0;
      m_cnt = m_cnt + int'(acc) - int'(fire);
      if (acc)  m_next = m_next + 2'd1;
      if (fire) m_act = m_act + 2'd1;
    end
  endtask

  // drive at negedge, check before the next posedge, then advance the model
  task automatic cyc(bit en, bit wr, bit wd, bit rdy, bit cv, bit [1:0] cid);
    @(negedge clk);
    enable = en; submit_wr = wr; submit_wdata = wd;
    q_ready = rdy; cmpl_valid = cv; cmpl_id = cid;
    #2;
    check_outputs();
    @(posedge clk);
    model_step();
  endtask

  initial begin
    m_sub = 0; m_next = 0; m_act = 0; m_cnt = 0; m_done = 0; m_evt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1 reset state
    chk("R1 submit_bit", submit_bit, 0);
    chk("R1 q_valid", q_valid, 0);
    chk("R1 next_id", next_id, 0);
    chk("R1 active_id", active_id, 0);
    chk("R1 done_bits", done_bits, 0);
    chk("R1 queued_evt", queued_evt, 0);

    // R4: writes while disabled are ignored
    cyc(0, 1, 1, 1, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R4 write while off", submit_bit, 0);
    // R2: write of 0 has no effect, write of 1 sets
    cyc(1, 1, 0, 0, 0, 0);
    cyc(1, 1, 1, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R2 set", submit_bit, 1);
    // fill four slots, one submit per ID
    for (int i = 0; i < 4; i++) begin
      cyc(1, 0, 0, 1, 0, 0);
      cyc(1, 1, 1, 0, 0, 0);
    end
    // R10: fifth request held with submit bit at 1
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 1, 0, 0);
    chk("R10 held", submit_bit, 1);
    chk("R10 no valid", q_valid, 0);
    // complete ID 0, slot frees, request with ID 0 goes out
    cyc(1, 0, 0, 0, 1, 2'd0);
    cyc(1, 0, 0, 1, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R6 id0 re-issued clears", done_bits[0], 0);
    // complete the rest in order
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 1, m_act);
    // R7: completion with nothing outstanding is ignored
    cyc(1, 0, 0, 0, 1, 2'd0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R8 idle active=next", active_id, next_id);
    // R5: disable resets the next ID
    cyc(0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R5 next zero after off", next_id, 0);

    // constrained random phase, fixed seed
    void'($urandom(32'h5A17));
    for (int n = 0; n < 6000; n++) begin
      bit en, wr, wd, rdy, cv;
      bit [1:0] cid;
      en  = ($urandom_range(0, 59) != 0);
      wr  = ($urandom_range(0, 2) == 0);
      wd  = ($urandom_range(0, 3) != 0);
      rdy = ($urandom_range(0, 2) != 0);
      cv  = 1'b0;
      cid = 2'($urandom_range(0, 3));
      if (m_cnt > 0 && $urandom_range(0, 3) == 0) begin
        cv = 1'b1; cid = m_act;
      end else if (m_cnt == 0 && $urandom_range(0, 7) == 0) begin
        cv = 1'b1;
      end
      cyc(en, wr, wd, rdy, cv, cid);
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule